// File: doc/BRIEF.md
# Four-Bank Byte Memory with Address-Decoded Bank Select

This block is a 4096-word by 8-bit synchronous memory. Its storage is split into four identical banks of 1024 bytes each. A small one-hot decoder looks at the two most significant address bits, gated by an access strobe, and raises exactly one bank-select line. The remaining ten address bits go unchanged to every bank as the word index.

A single direction line sets the kind of transfer and is shared by all banks. Low means the write data is stored at the addressed byte on the clock edge. High means the addressed byte is fetched into the bank's output register. Only the bank that accepted a read puts its byte on the result bus in the following cycle; every other bank contributes zero. The bus therefore reads zero in any cycle that does not follow a read.

The interface is a plain per-cycle access port with no back-pressure: the memory accepts one access every cycle the strobe is high and never stalls. Reset clears only the output path; the stored bytes are not initialised.

Top module: `banked_byte_ram`

## Requirements
- R1: The memory holds 4096 independent bytes, and a byte written at any address in 0..4095 is later read back unchanged from that address.
- R2: Address bits [11:10] select the bank (value k selects bank k, covering addresses k*1024 to k*1024+1023), and bits [9:0] pick the byte within that bank.
- R3: With `acc_en` high, `rd_wr_n` = 0 stores `wr_byte` at `mem_addr` and `rd_wr_n` = 1 reads the byte at `mem_addr`.
- R4: Read data appears on `rd_byte` in the cycle right after the clock edge that accepted the read, which is one cycle of latency.
- R5: A read of an address in the cycle right after a write to the same address returns the newly written byte.
- R6: A write changes only the addressed byte in the selected bank. Bytes at the same low-order offset in the other three banks keep their values.
- R7: `rd_byte` is zero in any cycle that does not follow an accepted read, including the cycle after a write or an idle cycle.
- R8: While `rst_n` is low and in the first cycle after it, `rd_byte` is zero.
- R9: With `acc_en` low, no bank is selected: nothing is stored whatever `rd_wr_n` and `wr_byte` hold, and the next cycle's `rd_byte` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the output path |
| acc_en | input | 1 | Access strobe; high performs the access given by `rd_wr_n` |
| rd_wr_n | input | 1 | Direction: 1 = read, 0 = write |
| mem_addr | input | 12 | Byte address; [11:10] bank, [9:0] byte within bank |
| wr_byte | input | 8 | Byte to store on a write |
| rd_byte | output | 8 | Byte fetched by the previous cycle's read, else zero |

## Verification
A write takes effect at the edge that samples it, so its result can only be seen through a read issued in a later cycle. A read's byte is due on `rd_byte` one edge after the read is sampled. The bench drives each access on a falling edge, waits for the next rising edge, and compares `rd_byte` at the falling edge after that. That single-cycle window also checks the zero level after writes and idle cycles. Bank aliasing is exposed by writing distinct bytes at the same low-order offset in every bank and then reading each one back.

// File: rtl/bram4_pkg.sv
package bram4_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned NUM_BANK = 1 << SEL_W;
  localparam int unsigned IDX_W    = ADDR_W - SEL_W;
  localparam int unsigned BANK_WORDS = 1 << IDX_W;
endpackage

// File: rtl/bram4_bank_decode.sv
module bram4_bank_decode #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned N_OUT = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [N_OUT-1:0] cs
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_line
    assign cs[k] = en && (sel == SEL_W'(k));
  end

  // R9: a low strobe leaves every bank deselected
  p_idle_no_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (cs == '0));
  // R2: at most one bank selected at a time
  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs));
endmodule

// File: rtl/bram4_bank.sv
module bram4_bank #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned IDX_W  = 10,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd_wr_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              driving
);
  logic [WORD_W-1:0] store [DEPTH];
  logic [WORD_W-1:0] fetch_q;
  logic              drv_q;

  wire do_write = cs && !rd_wr_n;
  wire do_read  = cs &&  rd_wr_n;

  always_ff @(posedge clk) begin
    if (do_write) store[idx] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_q   <= 1'b0;
      fetch_q <= '0;
    end else begin
      drv_q <= do_read;
      if (do_read) fetch_q <= store[idx];
    end
  end

  assign dout    = drv_q ? fetch_q : '0;
  assign driving = drv_q;

  // R7: an idle bank puts nothing on the shared bus
  p_quiet_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !driving |-> (dout == '0));
endmodule

// File: rtl/banked_byte_ram.sv
module banked_byte_ram
  import bram4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              rd_wr_n,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [NUM_BANK-1:0] bank_cs;
  logic [NUM_BANK-1:0] bank_drv;
  logic [BYTE_W-1:0]   bank_out [NUM_BANK];

  bram4_bank_decode #(.SEL_W(SEL_W)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (acc_en),
    .sel   (mem_addr[ADDR_W-1 -: SEL_W]),
    .cs    (bank_cs)
  );

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    bram4_bank #(.WORD_W(BYTE_W), .IDX_W(IDX_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs      (bank_cs[b]),
      .rd_wr_n (rd_wr_n),
      .idx     (mem_addr[IDX_W-1:0]),
      .din     (wr_byte),
      .dout    (bank_out[b]),
      .driving (bank_drv[b])
    );
  end

  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < NUM_BANK; b++) rd_byte |= bank_out[b];
  end

  // R2: only one bank answers a read
  p_single_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_drv));
  // R2 R4: the bank named by the upper address bits answers next cycle
  p_bank_answers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && rd_wr_n) |=> (bank_drv == (NUM_BANK'(1) << $past(mem_addr[ADDR_W-1 -: SEL_W]))));
  // R7: no read accepted means a zero bus next cycle
  p_zero_after_nonread_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && rd_wr_n) |=> (rd_byte == '0));
endmodule

// File: tb/banked_byte_ram_bench.sv
module banked_byte_ram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;
  // {acc_en, rd_wr_n, addr[11:0], wr_byte[7:0], expected rd_byte[7:0]}
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 12'h000, 8'hA5, 8'h00},  // R3 R7 write bank0
    {1'b1, 1'b1, 12'h000, 8'h00, 8'hA5},  // R5 back-to-back read
    {1'b1, 1'b0, 12'h400, 8'h3C, 8'h00},  // R2 bank1 offset 0
    {1'b1, 1'b0, 12'h800, 8'hC3, 8'h00},  // R2 bank2 offset 0
    {1'b1, 1'b0, 12'hC00, 8'h5A, 8'h00},  // R2 bank3 offset 0
    {1'b1, 1'b0, 12'hFFF, 8'h81, 8'h00},  // R1 top address
    {1'b1, 1'b1, 12'h400, 8'h00, 8'h3C},  // R2 R4
    {1'b1, 1'b1, 12'h800, 8'h00, 8'hC3},  // R2
    {1'b1, 1'b1, 12'hC00, 8'h00, 8'h5A},  // R2
    {1'b1, 1'b1, 12'hFFF, 8'h00, 8'h81},  // R1
    {1'b1, 1'b1, 12'h000, 8'h00, 8'hA5},  // R6 bank0 untouched
    {1'b1, 1'b0, 12'h3FF, 8'h77, 8'h00},  // R2 bank0 last byte
    {1'b1, 1'b1, 12'h3FF, 8'h00, 8'h77},  // R5
    {1'b0, 1'b0, 12'h000, 8'hFF, 8'h00},  // R9 strobe low, no store
    {1'b1, 1'b1, 12'h000, 8'h00, 8'hA5},  // R9 old byte kept
    {1'b1, 1'b0, 12'h401, 8'h11, 8'h00},  // R6 neighbour write
    {1'b1, 1'b1, 12'h401, 8'h00, 8'h11},  // R5
    {1'b1, 1'b1, 12'h400, 8'h00, 8'h3C}   // R6 neighbour unchanged
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0;
  logic       rd_wr_n = 1'b0;
  logic [11:0] mem_addr = '0;
  logic [7:0] wr_byte = '0;
  logic [7:0] rd_byte;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_byte_ram u_banked_byte_ram (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .rd_wr_n(rd_wr_n),
    .mem_addr(mem_addr), .wr_byte(wr_byte), .rd_byte(rd_byte)
  );

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (rd_byte !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_byte=%02h expected=%02h", req, rd_byte, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step(input logic en, input logic rw, input logic [11:0] a,
                      input logic [7:0] d, input string req, input logic [7:0] exp);
    acc_en = en; rd_wr_n = rw; mem_addr = a; wr_byte = d;
    @(posedge clk);
    @(negedge clk);
    check(req, exp);
  endtask

  initial begin
    @(negedge clk);
    acc_en = 1'b1; rd_wr_n = 1'b1; mem_addr = 12'h000;
    @(posedge clk); @(negedge clk);
    check("R8 during reset", 8'h00);
    acc_en = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 after reset", 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][29], VEC[i][28], VEC[i][27:16], VEC[i][15:8],
           $sformatf("R3 vector %0d", i), VEC[i][7:0]);
    end

    // R2 R6: same offset in every bank, distinct bytes, then read all back
    for (int k = 0; k < 4; k++)
      step(1'b1, 1'b0, 12'(k*1024 + 300), 8'(8'h20 + k*17), "R6 alias write", 8'h00);
    for (int k = 3; k >= 0; k--)
      step(1'b1, 1'b1, 12'(k*1024 + 300), 8'h00, "R2 alias read", 8'(8'h20 + k*17));

    // R7: a read followed by an idle cycle drops the bus to zero
    step(1'b1, 1'b1, 12'hFFF, 8'h00, "R4 read", 8'h81);
    step(1'b0, 1'b1, 12'hFFF, 8'h00, "R7 idle after read", 8'h00);

    // R1: byte walk across the whole space with computed data
    for (int a = 0; a < 4096; a += 257)
      step(1'b1, 1'b0, 12'(a), 8'(a ^ (a >> 4)), "R1 walk write", 8'h00);
    for (int a = 0; a < 4096; a += 257)
      step(1'b1, 1'b1, 12'(a), 8'h00, "R1 walk read", 8'(a ^ (a >> 4)));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule